// File: doc/BRIEF.md
# Clock Divisor Register with Doze Control

This block holds a 16-bit clock-divisor control word and acts on its contents. A simple single-cycle bus writes the word and reads it back at all times. Three of its fields choose divide factors for the oscillator postscaler, the PLL input prescaler and the PLL output postscaler. The block presents each of these as a decoded divide value, ready for the clock tree to use.

The fourth part of the word controls doze mode. Doze mode slows the processor domain relative to the peripheral clock. The block produces a processor clock-enable strobe that is high on one peripheral clock out of every N, where N is the active ratio. Writes to the doze fields are limited by each other:
- The ratio cannot change while doze is on.
- Doze cannot be turned on with a ratio of 1:1.

When the recovery bit is set, an interrupt pulse turns doze off and the strobe returns to 1:1 at once. Only the power-on reset input clears the register.

Top module: `doze_clk_ctl`

## Requirements
- R1: While `porRstN` is low, and after it is released with no write, `busRdData` reads 16'h3040. In that state `frcDiv` is 1, `pllPostDiv` is 4, `pllPreDiv` is 2 and `cpuClkEn` is high on every cycle.
- R2: A write stores its data in the following bit layout: bit 15 recovery enable, bits 14:12 doze ratio code, bit 11 doze enable, bits 10:8 oscillator postscaler code, bits 7:6 PLL postscaler code, bits 4:0 PLL prescaler code. Bit 5 always reads 0.
- R3: While the stored doze enable is 1, a write leaves the doze ratio code unchanged. The other fields of that write are still applied.
- R4: A write with bit 11 set leaves doze enable unchanged when the ratio code that results from the write is 000. The resulting ratio code is the written code if doze was off before the write, and the held code otherwise. A write with bit 11 clear turns doze off.
- R5: An `irqPulse` cycle with the stored recovery bit at 1 clears doze enable, and this takes priority over a write that sets it in the same cycle. With the recovery bit at 0, `irqPulse` has no effect.
- R6: Whenever doze enable is 0, `cpuClkEn` is high on every cycle, whatever the ratio code holds.
- R7: With doze enabled and ratio code n, `cpuClkEn` is a one-cycle strobe repeating every 2^n cycles. Any change of the active ratio restarts the count, so the strobe is high in the first cycle under the new ratio.
- R8: `frcDiv` decodes the oscillator postscaler code c as 2^c for c from 0 to 6, and as 256 for code 7.
- R9: `pllPostDiv` decodes PLL postscaler code 00 as 2, 01 as 4 and 11 as 8. The reserved code 10 is stored and read back as written, while `pllPostDiv` keeps its previous value.
- R10: `pllPreDiv` equals the PLL prescaler code plus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| porRstN | input | 1 | Power-on reset, active low, the only reset of the register |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Current register contents |
| irqPulse | input | 1 | Interrupt event, one cycle per event |
| cpuClkEn | output | 1 | Processor-domain clock enable strobe |
| frcDiv | output | 9 | Decoded oscillator postscaler divide value |
| pllPostDiv | output | 4 | Decoded PLL output divide value |
| pllPreDiv | output | 6 | Decoded PLL input divide value |

## Verification
Some rules are checked by the assertions on every cycle:
- Doze is never on with a zero ratio.
- The ratio holds while doze is on.
- An enabled recovery interrupt always turns doze off.
- The strobe stays high while doze is off.
- Bit 5 reads 0 and the PLL output divide is always a legal value.

Other behaviour can only be shown by the bench's directed scenarios. This covers the exact strobe spacing for each ratio and its restart on a ratio change, and the same-cycle interplay between the enable and ratio fields. It also covers interrupt priority over a simultaneous write, the reserved postscaler code holding the previous divide, and the reset value.

// File: rtl/doze_clk_pkg.sv
package doze_clk_pkg;
  localparam int DATA_W     = 16;
  localparam int RATIO_W    = 3;
  localparam int FRC_W      = 3;
  localparam int POST_W     = 2;
  localparam int PRE_W      = 5;
  localparam int CNT_W      = (1 << RATIO_W) - 1;
  localparam int FRC_DIV_W  = 9;
  localparam int POST_DIV_W = 4;
  localparam int PRE_DIV_W  = PRE_W + 1;

  // field positions (decoded by the clock tree and by software)
  localparam int ROI_BIT   = 15;
  localparam int RATIO_LSB = 12;
  localparam int EN_BIT    = 11;
  localparam int FRC_LSB   = 8;
  localparam int POST_LSB  = 6;
  localparam int PRE_LSB   = 0;

  localparam logic [RATIO_W-1:0] RATIO_RST = 3'd3;
  localparam logic [POST_W-1:0]  POST_RST  = 2'b01;
  localparam logic [POST_W-1:0]  POST_RSVD = 2'b10;

  typedef struct packed {
    logic loadRatio;  // take ratio field from bus
    logic setEn;      // turn doze on
    logic clrEn;      // turn doze off
    logic loadMisc;   // take remaining fields from bus
  } cdzStrobe_t;

  function automatic logic [FRC_DIV_W-1:0] frcDecode(input logic [FRC_W-1:0] code);
    logic [FRC_DIV_W-1:0] v;
    if (code == '1) v = FRC_DIV_W'(256);
    else            v = FRC_DIV_W'(1) << code;
    return v;
  endfunction

  function automatic logic [POST_DIV_W-1:0] postDecode(input logic [POST_W-1:0] code);
    logic [POST_DIV_W-1:0] v;
    case (code)
      2'b00:   v = POST_DIV_W'(2);
      2'b11:   v = POST_DIV_W'(8);
      default: v = POST_DIV_W'(4);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/doze_clk_ctrl.sv
module doze_clk_ctrl
  import doze_clk_pkg::*;
(
  input  logic               wrEn,
  input  logic [RATIO_W-1:0] wrRatio,
  input  logic               wrEnBit,
  input  logic               irqPulse,
  input  logic               curRoi,
  input  logic               curEn,
  input  logic [RATIO_W-1:0] curRatio,
  output cdzStrobe_t         strb
);
  logic [RATIO_W-1:0] effRatio;
  logic irqClr;

  always_comb begin
    strb.loadRatio = wrEn && !curEn;
    effRatio       = strb.loadRatio ? wrRatio : curRatio;
    irqClr         = irqPulse && curRoi;
    strb.clrEn     = irqClr || (wrEn && !wrEnBit);
    strb.setEn     = wrEn && wrEnBit && (effRatio != '0) && !irqClr;
    strb.loadMisc  = wrEn;
  end

  always_comb begin
    a_r5_no_set_on_irq: assert (!(irqClr && strb.setEn))
      else $error("R5: set and recovery clear in same cycle");
  end
endmodule

// File: rtl/doze_clk_dp.sv
module doze_clk_dp
  import doze_clk_pkg::*;
(
  input  logic                  clk,
  input  logic                  porRstN,
  input  cdzStrobe_t            strb,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  irqPulse,
  output logic                  roi,
  output logic                  dozeEn,
  output logic [RATIO_W-1:0]    ratio,
  output logic [DATA_W-1:0]     rdData,
  output logic                  cpuClkEn,
  output logic [FRC_DIV_W-1:0]  frcDiv,
  output logic [POST_DIV_W-1:0] pllPostDiv,
  output logic [PRE_DIV_W-1:0]  pllPreDiv
);
  logic [FRC_W-1:0]  frcSel;
  logic [POST_W-1:0] postSel;
  logic [PRE_W-1:0]  preSel;
  logic [CNT_W-1:0]  cnt, cntNext, cntMask;
  logic [RATIO_W-1:0] nRatio, activeNow, activeNext;
  logic nEn;
  logic [POST_W-1:0] wrPost;

  assign wrPost = wrData[POST_LSB +: POST_W];

  // register fields
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      roi     <= 1'b0;
      ratio   <= RATIO_RST;
      dozeEn  <= 1'b0;
      frcSel  <= '0;
      postSel <= POST_RST;
      preSel  <= '0;
    end else begin
      ratio  <= nRatio;
      dozeEn <= nEn;
      if (strb.loadMisc) begin
        roi     <= wrData[ROI_BIT];
        frcSel  <= wrData[FRC_LSB +: FRC_W];
        postSel <= wrPost;
        preSel  <= wrData[PRE_LSB +: PRE_W];
      end
    end
  end

  // decoded PLL output divide keeps its last legal value
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                                   pllPostDiv <= postDecode(POST_RST);
    else if (strb.loadMisc && wrPost != POST_RSVD)  pllPostDiv <= postDecode(wrPost);
  end

  // doze strobe generator
  always_comb begin
    nRatio     = strb.loadRatio ? wrData[RATIO_LSB +: RATIO_W] : ratio;
    nEn        = strb.clrEn ? 1'b0 : (strb.setEn ? 1'b1 : dozeEn);
    activeNow  = dozeEn ? ratio : '0;
    activeNext = nEn ? nRatio : '0;
    cntMask    = CNT_W'((1 << activeNow) - 1);
    cntNext    = (activeNext != activeNow) ? '0 : ((cnt + CNT_W'(1)) & cntMask);
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) cnt <= '0;
    else          cnt <= cntNext;
  end

  assign cpuClkEn = (cnt == '0);

  always_comb begin
    rdData = '0;
    rdData[ROI_BIT]                = roi;
    rdData[RATIO_LSB +: RATIO_W]   = ratio;
    rdData[EN_BIT]                 = dozeEn;
    rdData[FRC_LSB +: FRC_W]       = frcSel;
    rdData[POST_LSB +: POST_W]     = postSel;
    rdData[PRE_LSB +: PRE_W]       = preSel;
  end

  assign frcDiv    = frcDecode(frcSel);
  assign pllPreDiv = PRE_DIV_W'(preSel) + PRE_DIV_W'(2);

  a_r3_ratio_locked: assert property (@(posedge clk) disable iff (!porRstN)
    dozeEn |=> $stable(ratio)) else $error("R3: ratio changed while doze on");
  a_r4_no_zero_enable: assert property (@(posedge clk) disable iff (!porRstN)
    dozeEn |-> ratio != '0) else $error("R4: doze on with ratio 0");
  a_r5_irq_recovers: assert property (@(posedge clk) disable iff (!porRstN)
    (irqPulse && roi) |=> !dozeEn) else $error("R5: interrupt did not clear doze");
  a_r6_full_rate: assert property (@(posedge clk) disable iff (!porRstN)
    !dozeEn |-> cpuClkEn) else $error("R6: strobe low with doze off");
  a_r2_bit5_zero: assert property (@(posedge clk) disable iff (!porRstN)
    rdData[5] == 1'b0) else $error("R2: bit 5 read as 1");
  a_r9_legal_post: assert property (@(posedge clk) disable iff (!porRstN)
    $countones(pllPostDiv) == 1 && pllPostDiv != POST_DIV_W'(1))
    else $error("R9: illegal PLL output divide");
endmodule

// File: rtl/doze_clk_ctl.sv
module doze_clk_ctl
  import doze_clk_pkg::*;
(
  input  logic                  clk,
  input  logic                  porRstN,
  input  logic                  busWrEn,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  logic                  irqPulse,
  output logic                  cpuClkEn,
  output logic [FRC_DIV_W-1:0]  frcDiv,
  output logic [POST_DIV_W-1:0] pllPostDiv,
  output logic [PRE_DIV_W-1:0]  pllPreDiv
);
  cdzStrobe_t strb;
  logic roi, dozeEn;
  logic [RATIO_W-1:0] ratio;

  doze_clk_ctrl u_ctrl (
    .wrEn     (busWrEn),
    .wrRatio  (busWrData[RATIO_LSB +: RATIO_W]),
    .wrEnBit  (busWrData[EN_BIT]),
    .irqPulse (irqPulse),
    .curRoi   (roi),
    .curEn    (dozeEn),
    .curRatio (ratio),
    .strb     (strb)
  );

  doze_clk_dp u_dp (
    .clk        (clk),
    .porRstN    (porRstN),
    .strb       (strb),
    .wrData     (busWrData),
    .irqPulse   (irqPulse),
    .roi        (roi),
    .dozeEn     (dozeEn),
    .ratio      (ratio),
    .rdData     (busRdData),
    .cpuClkEn   (cpuClkEn),
    .frcDiv     (frcDiv),
    .pllPostDiv (pllPostDiv),
    .pllPreDiv  (pllPreDiv)
  );
endmodule

// File: tb/test_doze_clk_ctl.sv
module test_doze_clk_ctl;
  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic irqPulse = 1'b0;
  logic [15:0] busRdData;
  logic cpuClkEn;
  logic [8:0] frcDiv;
  logic [3:0] pllPostDiv;
  logic [5:0] pllPreDiv;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  doze_clk_ctl i_doze_clk_ctl (
    .clk(clk), .porRstN(porRstN), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqPulse(irqPulse), .cpuClkEn(cpuClkEn),
    .frcDiv(frcDiv), .pllPostDiv(pllPostDiv), .pllPreDiv(pllPreDiv)
  );

  function automatic logic [15:0] mk(input logic roi, input logic [2:0] r, input logic en,
                                     input logic [2:0] frc, input logic [1:0] post,
                                     input logic [4:0] pre);
    return {roi, r, en, frc, post, 1'b0, pre};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] d);
    @(negedge clk); busWrEn = 1'b1; busWrData = d;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic pulseIrq();
    @(negedge clk); irqPulse = 1'b1;
    @(negedge clk); irqPulse = 1'b0;
  endtask

  // sample strobe at this and following negedges: high exactly every n cycles
  task automatic strobeTrain(input string req, input int n, input int len);
    for (int k = 0; k < len; k++) begin
      chk(req, cpuClkEn, (k % n) == 0);
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    @(negedge clk); porRstN = 1'b0;
    @(negedge clk);
    chk("R1 in reset", busRdData, 16'h3040);
    porRstN = 1'b1;
    @(negedge clk);
    chk("R1 value", busRdData, 16'h3040);
    chk("R1 frcDiv", frcDiv, 1);
    chk("R1 postDiv", pllPostDiv, 4);
    chk("R1 preDiv", pllPreDiv, 2);
    strobeTrain("R1 strobe", 1, 4);
  endtask

  task automatic tLayout();
    busWrite(16'h0000 | mk(1, 3'd5, 0, 3'd2, 2'b11, 5'd9) | 16'h0020);
    chk("R2 readback", busRdData, mk(1, 3'd5, 0, 3'd2, 2'b11, 5'd9));
    chk("R8 frc code2", frcDiv, 4);
    chk("R9 post 11", pllPostDiv, 8);
    chk("R10 pre 9", pllPreDiv, 11);
    busWrite(mk(0, 3'd5, 0, 3'd6, 2'b00, 5'd31));
    chk("R8 frc code6", frcDiv, 64);
    chk("R9 post 00", pllPostDiv, 2);
    chk("R10 pre 31", pllPreDiv, 33);
    busWrite(mk(0, 3'd5, 0, 3'd7, 2'b10, 5'd0));
    chk("R8 frc code7", frcDiv, 256);
    chk("R9 reserved stored", busRdData[7:6], 2'b10);
    chk("R9 reserved holds", pllPostDiv, 2);
  endtask

  task automatic tEnableRules();
    busWrite(mk(0, 3'd0, 1, 3'd0, 2'b01, 5'd0));
    chk("R4 set blocked ratio0", busRdData, mk(0, 3'd0, 0, 3'd0, 2'b01, 5'd0));
    strobeTrain("R6 strobe ratio0", 1, 3);
    busWrite(mk(0, 3'd2, 1, 3'd0, 2'b01, 5'd0));
    chk("R4 set with new ratio", busRdData, mk(0, 3'd2, 1, 3'd0, 2'b01, 5'd0));
    strobeTrain("R7 ratio 4", 4, 9);
    busWrite(mk(0, 3'd0, 1, 3'd1, 2'b01, 5'd0));
    chk("R3 ratio locked", busRdData, mk(0, 3'd2, 1, 3'd1, 2'b01, 5'd0));
    busWrite(mk(0, 3'd6, 0, 3'd1, 2'b01, 5'd0));
    chk("R3 clear keeps ratio", busRdData, mk(0, 3'd2, 0, 3'd1, 2'b01, 5'd0));
    strobeTrain("R6 doze off", 1, 4);
    busWrite(mk(0, 3'd3, 1, 3'd0, 2'b01, 5'd0));
    strobeTrain("R7 ratio 8", 8, 17);
    busWrite(mk(0, 3'd0, 0, 3'd0, 2'b01, 5'd0));
    busWrite(mk(0, 3'd7, 1, 3'd0, 2'b01, 5'd0));
    strobeTrain("R7 ratio 128", 128, 260);
  endtask

  task automatic tIrq();
    busWrite(mk(0, 3'd0, 0, 3'd0, 2'b01, 5'd0));
    busWrite(mk(0, 3'd3, 1, 3'd0, 2'b01, 5'd0));
    pulseIrq();
    chk("R5 roi0 no effect", busRdData[11], 1'b1);
    busWrite(mk(1, 3'd3, 1, 3'd0, 2'b01, 5'd0));
    repeat (2) @(negedge clk);
    chk("R7 mid-count low", cpuClkEn, 1'b0);
    pulseIrq();
    chk("R5 irq clears", busRdData[11], 1'b0);
    chk("R7 restart on return", cpuClkEn, 1'b1);
    strobeTrain("R6 after irq", 1, 3);
    @(negedge clk); irqPulse = 1'b1; busWrEn = 1'b1;
    busWrData = mk(1, 3'd4, 1, 3'd0, 2'b01, 5'd0);
    @(negedge clk); irqPulse = 1'b0; busWrEn = 1'b0;
    chk("R5 irq beats set", busRdData[11], 1'b0);
    chk("R5 ratio still written", busRdData[14:12], 3'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    tReset();
    tLayout();
    tEnableRules();
    tIrq();
    tReset();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule